// File: doc/BRIEF.md
# Operand Address Sequencer

This block takes one 6-bit operand specifier of a 16-bit two-address machine and works out where the operand lives. The specifier's low three bits name one of eight registers; its high three bits give the addressing mode, and the lowest mode bit adds one level of indirection. The block reads the named register through a register-file read port. It posts pointer updates through a write port. It runs the word reads the mode needs over a simple memory read port with a valid handshake. It then pulses `done` with either a final operand address or a flag saying the operand is the register itself.

Register 7 is the program counter and register 6 the stack pointer. Auto-increment through the program counter gives literals and absolute addresses. Indexing through it gives position-independent addresses. The index word is taken from memory at the program counter, which then moves on by one word. Fetching operand data, ALU work and the rest of instruction decode are outside the block.

Top module: `opAddrSeq`

## Requirements
- R1: `spec[2:0]` selects the register and `spec[5:3]` the mode. With mode 0 the block raises `isRegDirect`, reports the register number on `regNum`, issues no memory read and no register write, and pulses `done` two cycles after the start.
- R2: Mode 1 returns the unchanged register contents as `opAddr` and writes no register.
- R3: Mode 2 returns the register contents as `opAddr` and writes back the register plus 1 when `isByte` is 1, or plus 2 when `isByte` is 0, for registers 0 to 5.
- R4: Mode 4 subtracts the same step (1 for byte, 2 for word, registers 0 to 5) from the register, writes the result back and returns it as `opAddr`.
- R5: Modes 2 and 4 on register 6 or 7 always step by 2, whatever `isByte` says.
- R6: Mode 3 (step up after use) and mode 5 (step down before use) step the register by 2 even for byte operands. They read one word at the pointer and return that word as `opAddr`.
- R7: Mode 6 reads the index word at the program counter and writes back the program counter plus 2. It returns the selected register plus the index word, where register 7 already reads the advanced value.
- R8: Mode 7 forms the same sum as mode 6, reads one word at that sum and returns that word as `opAddr`.
- R9: Each specifier causes at most one register write: exactly one in modes 2 to 7 and none in modes 0 and 1.
- R10: `done` is a one-cycle pulse given only after every memory read has been accepted. `memRdReq` and `memRdAddr` hold steady until `memRdValid`. With w wait cycles per read, `done` comes 2 cycles after start for modes 0, 1, 2 and 4, 3+w for modes 3 and 5, 4+w for mode 6, and 5+2w for mode 7.
- R11: A `start` that arrives while a specifier is in progress is ignored and does not change the result of the current specifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a specifier (taken only when idle) |
| spec | input | 6 | Operand specifier: mode in [5:3], register in [2:0] |
| isByte | input | 1 | Byte-sized operand when 1, word when 0 |
| regRdSel | output | 3 | Register-file read select |
| regRdData | input | 16 | Register-file read data (combinational) |
| regWrEn | output | 1 | Register-file write strobe |
| regWrSel | output | 3 | Register-file write select |
| regWrData | output | 16 | Register-file write data |
| memRdReq | output | 1 | Memory read request, held until accepted |
| memRdAddr | output | 16 | Memory read address |
| memRdValid | input | 1 | Memory read accepted, data valid this cycle |
| memRdData | input | 16 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| isRegDirect | output | 1 | Operand is the register itself |
| regNum | output | 3 | Register named by the specifier |
| opAddr | output | 16 | Final operand address |

## Verification
Each result has a due cycle that follows from the mode and the memory wait count. `done` is due 2, 3+w, 4+w or 5+2w edges after the edge that takes `start`. The bench counts edges from that point and samples on the falling edge, so the count it compares is exact. The register write lands in the first cycle after start, so the register-file contents and the write count are compared once `done` is seen. The bench then looks one more falling edge on to confirm that `done` has dropped.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam int REG_SEL_W = 3;
  localparam int MODE_W    = 3;
  localparam int SPEC_W    = REG_SEL_W + MODE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READREG, ST_IDX, ST_BASE, ST_INDIR, ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    ASRC_REG, ASRC_DEC, ASRC_SUM, ASRC_MEM
  } addrSrc_t;

  typedef struct packed {
    logic     latchSpec;
    logic     selPc;
    logic     regWr;
    logic     wbInc;
    logic     ldAddr;
    addrSrc_t addrSrc;
    logic     ldIdx;
    logic     memReq;
  } ctlStrobes_t;
endpackage

// File: rtl/opAddrPath.sv
module opAddrPath
  import opaddr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  logic [SPEC_W-1:0]     specIn,
  input  logic                  byteIn,
  output logic [MODE_W-1:0]     modeQ,
  output logic [REG_SEL_W-1:0]  regRdSel,
  input  logic [DATA_W-1:0]     regRdData,
  output logic                  regWrEn,
  output logic [REG_SEL_W-1:0]  regWrSel,
  output logic [DATA_W-1:0]     regWrData,
  output logic                  memRdReq,
  output logic [DATA_W-1:0]     memRdAddr,
  input  logic                  memRdValid,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [DATA_W-1:0]     opAddr,
  output logic                  isRegDirect,
  output logic [REG_SEL_W-1:0]  regNum
);
  localparam int REG_CNT    = 1 << REG_SEL_W;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [REG_SEL_W-1:0] PC_IDX = REG_SEL_W'(REG_CNT - 1);
  localparam logic [REG_SEL_W-1:0] SP_IDX = REG_SEL_W'(REG_CNT - 2);

  logic [REG_SEL_W-1:0] regQ;
  logic                 byteQ;
  logic [DATA_W-1:0]    addrQ;
  logic [DATA_W-1:0]    idxQ;
  logic                 stackReg;
  logic                 narrowStep;
  logic [DATA_W-1:0]    step;
  logic [DATA_W-1:0]    addrNext;

  // Specifier, size and index capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ  <= '0;
      modeQ <= '0;
      byteQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      if (ctl.latchSpec) begin
        regQ  <= specIn[REG_SEL_W-1:0];
        modeQ <= specIn[SPEC_W-1:REG_SEL_W];
        byteQ <= byteIn;
      end
      if (ctl.ldIdx) idxQ <= memRdData;
    end
  end

  // Step size: one byte only for sized modes on ordinary registers
  assign stackReg   = (regQ >= SP_IDX);
  assign narrowStep = byteQ && !modeQ[0] && !stackReg && !ctl.selPc;
  assign step       = narrowStep ? DATA_W'(1) : DATA_W'(WORD_BYTES);

  assign regRdSel  = ctl.selPc ? PC_IDX : regQ;
  assign regWrSel  = regRdSel;
  assign regWrEn   = ctl.regWr;
  assign regWrData = ctl.wbInc ? (regRdData + step) : (regRdData - step);

  always_comb begin
    unique case (ctl.addrSrc)
      ASRC_REG: addrNext = regRdData;
      ASRC_DEC: addrNext = regRdData - step;
      ASRC_SUM: addrNext = regRdData + idxQ;
      default:  addrNext = memRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (ctl.ldAddr) addrQ <= addrNext;
  end

  assign memRdReq    = ctl.memReq;
  assign memRdAddr   = addrQ;
  assign opAddr      = addrQ;
  assign isRegDirect = (modeQ == '0);
  assign regNum      = regQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdValid |=> memRdReq && $stable(memRdAddr)) // R10
    else $error("read request dropped or address moved before acceptance");

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ((regWrData - regRdData) == DATA_W'(1)) || ((regWrData - regRdData) == DATA_W'(2))
             || ((regRdData - regWrData) == DATA_W'(1)) || ((regRdData - regWrData) == DATA_W'(2))) // R3
    else $error("pointer step outside 1 or 2");

  AST_STACK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && (regWrSel >= SP_IDX) |->
      (regWrData == regRdData + DATA_W'(2)) || (regWrData == regRdData - DATA_W'(2))) // R5
    else $error("stack or program counter stepped by other than a word");
endmodule

// File: rtl/opAddrCtl.sv
module opAddrCtl
  import opaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] modeQ,
  input  logic              memRdValid,
  output ctlStrobes_t       ctl,
  output logic              done
);
  seqState_t state, nxt;
  logic      wrSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl  = '0;
    done = 1'b0;
    nxt  = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.latchSpec = 1'b1;
          nxt = ST_READREG;
        end
      end
      ST_READREG: begin
        ctl.selPc   = (modeQ[2:1] == 2'b11);
        ctl.ldAddr  = (modeQ != 3'd0);
        ctl.addrSrc = (modeQ[2:1] == 2'b10) ? ASRC_DEC : ASRC_REG;
        ctl.regWr   = (modeQ[2:1] != 2'b00);
        ctl.wbInc   = (modeQ[2:1] != 2'b10);
        unique case (modeQ)
          3'd0, 3'd1, 3'd2, 3'd4: nxt = ST_DONE;
          3'd3, 3'd5:             nxt = ST_INDIR;
          default:                nxt = ST_IDX;
        endcase
      end
      ST_IDX: begin
        ctl.memReq = 1'b1;
        ctl.ldIdx  = memRdValid;
        if (memRdValid) nxt = ST_BASE;
      end
      ST_BASE: begin
        ctl.ldAddr  = 1'b1;
        ctl.addrSrc = ASRC_SUM;
        nxt = modeQ[0] ? ST_INDIR : ST_DONE;
      end
      ST_INDIR: begin
        ctl.memReq  = 1'b1;
        ctl.ldAddr  = memRdValid;
        ctl.addrSrc = ASRC_MEM;
        if (memRdValid) nxt = ST_DONE;
      end
      default: begin
        done = 1'b1;
        nxt  = ST_IDLE;
      end
    endcase
  end

  // Tracks whether this specifier already posted a register write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrSeen <= 1'b0;
    else if (state == ST_IDLE) wrSeen <= 1'b0;
    else if (ctl.regWr)        wrSeen <= 1'b1;
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.regWr |-> !wrSeen) // R9
    else $error("second register write in one specifier");

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) // R10
    else $error("done held longer than one cycle");

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ctl.memReq) // R10
    else $error("done while a read is outstanding");

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !ctl.latchSpec) // R11
    else $error("specifier recaptured while busy");
endmodule

// File: rtl/opAddrSeq.sv
module opAddrSeq
  import opaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [5:0]  spec,
  input  logic        isByte,
  output logic [2:0]  regRdSel,
  input  logic [15:0] regRdData,
  output logic        regWrEn,
  output logic [2:0]  regWrSel,
  output logic [15:0] regWrData,
  output logic        memRdReq,
  output logic [15:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [15:0] memRdData,
  output logic        done,
  output logic        isRegDirect,
  output logic [2:0]  regNum,
  output logic [15:0] opAddr
);
  ctlStrobes_t       ctl;
  logic [MODE_W-1:0] modeQ;

  opAddrCtl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .modeQ      (modeQ),
    .memRdValid (memRdValid),
    .ctl        (ctl),
    .done       (done)
  );

  opAddrPath #(.DATA_W(16)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .specIn      (spec),
    .byteIn      (isByte),
    .modeQ       (modeQ),
    .regRdSel    (regRdSel),
    .regRdData   (regRdData),
    .regWrEn     (regWrEn),
    .regWrSel    (regWrSel),
    .regWrData   (regWrData),
    .memRdReq    (memRdReq),
    .memRdAddr   (memRdAddr),
    .memRdValid  (memRdValid),
    .memRdData   (memRdData),
    .opAddr      (opAddr),
    .isRegDirect (isRegDirect),
    .regNum      (regNum)
  );
endmodule

// File: tb/opAddrSeq_test.sv
`timescale 1ns/1ps
module opAddrSeq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  spec = '0;
  logic        isByte = 1'b0;
  logic [2:0]  regRdSel, regWrSel, regNum;
  logic [15:0] regRdData, regWrData, memRdAddr, memRdData, opAddr;
  logic        regWrEn, memRdReq, memRdValid, done, isRegDirect;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [15:0] rf [8];
  logic [15:0] rfInit [8];
  logic [15:0] expRf [8];
  logic        rfLoad = 1'b0;
  int          wrCount = 0;
  int          waitCnt = 0;
  int          waitCfg = 0;

  always #4 clk = ~clk;

  opAddrSeq uut (
    .clk(clk), .rstN(rstN), .start(start), .spec(spec), .isByte(isByte),
    .regRdSel(regRdSel), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .done(done), .isRegDirect(isRegDirect), .regNum(regNum), .opAddr(opAddr)
  );

  function automatic logic [15:0] memFn(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  assign regRdData  = rf[regRdSel];
  assign memRdData  = memFn(memRdAddr);
  assign memRdValid = memRdReq && (waitCnt == waitCfg);

  always @(posedge clk) begin
    if (rfLoad) begin
      for (int i = 0; i < 8; i++) rf[i] <= rfInit[i];
      wrCount <= 0;
    end else if (regWrEn) begin
      rf[regWrSel] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (memRdReq && !memRdValid) waitCnt <= waitCnt + 1;
    else                         waitCnt <= 0;
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Stimulus vectors: {spec, isByte, wait cycles per read}
  localparam int NVEC = 16;
  localparam logic [9:0] VEC [NVEC] = '{
    {6'o03, 1'b0, 3'd0}, {6'o12, 1'b0, 3'd0}, {6'o21, 1'b1, 3'd0}, {6'o21, 1'b0, 3'd0},
    {6'o26, 1'b1, 3'd0}, {6'o27, 1'b1, 3'd0}, {6'o40, 1'b1, 3'd0}, {6'o46, 1'b1, 3'd0},
    {6'o34, 1'b1, 3'd1}, {6'o37, 1'b0, 3'd0}, {6'o55, 1'b1, 3'd2}, {6'o62, 1'b0, 3'd0},
    {6'o67, 1'b0, 3'd1}, {6'o73, 1'b1, 3'd2}, {6'o77, 1'b0, 3'd0}, {6'o17, 1'b0, 3'd0}
  };

  // Independent model of the requirements
  task automatic model(input logic [5:0] s, input logic b, input int w,
                       output logic [15:0] eAddr, output logic eDir,
                       output int eLat, output int eWr, output string req);
    int rn = int'(s[2:0]);
    int m  = int'(s[5:3]);
    logic [15:0] st, x, sum;
    for (int i = 0; i < 8; i++) expRf[i] = rfInit[i];
    st = (b && rn < 6) ? 16'd1 : 16'd2;
    eDir = 1'b0; eAddr = 16'h0; eWr = 1; eLat = 2;
    case (m)
      0: begin eDir = 1'b1; eWr = 0; req = "R1"; end
      1: begin eAddr = expRf[rn]; eWr = 0; req = "R2"; end
      2: begin eAddr = expRf[rn]; expRf[rn] = expRf[rn] + st; req = (rn >= 6) ? "R5" : "R3"; end
      4: begin expRf[rn] = expRf[rn] - st; eAddr = expRf[rn]; req = (rn >= 6) ? "R5" : "R4"; end
      3: begin eAddr = memFn(expRf[rn]); expRf[rn] = expRf[rn] + 16'd2; eLat = 3 + w; req = "R6"; end
      5: begin expRf[rn] = expRf[rn] - 16'd2; eAddr = memFn(expRf[rn]); eLat = 3 + w; req = "R6"; end
      default: begin
        x = memFn(expRf[7]);
        expRf[7] = expRf[7] + 16'd2;
        sum = expRf[rn] + x;
        if (m == 6) begin eAddr = sum; eLat = 4 + w; req = "R7"; end
        else begin eAddr = memFn(sum); eLat = 5 + 2 * w; req = "R8"; end
      end
    endcase
  endtask

  task automatic runVec(input logic [5:0] s, input logic b, input int w, input bit poke);
    logic [15:0] eAddr;
    logic eDir;
    int eLat, eWr, n;
    string req;
    bit rfOk;
    for (int i = 0; i < 8; i++) rfInit[i] = (i == 7) ? 16'h0200 : 16'h1000 + 16'(i) * 16'h0111;
    model(s, b, w, eAddr, eDir, eLat, eWr, req);
    @(negedge clk); rfLoad = 1'b1; waitCfg = w;
    @(negedge clk); rfLoad = 1'b0;
    spec = s; isByte = b; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 60) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (poke && n == 2) begin start = 1'b1; spec = 6'o05; isByte = 1'b1; end
      if (poke && n == 3) start = 1'b0;
    end
    check(n == eLat, "R10 latency", n, eLat);
    check(isRegDirect == eDir, "R1 direct flag", int'(isRegDirect), int'(eDir));
    check(regNum == s[2:0], "R1 register number", int'(regNum), int'(s[2:0]));
    if (!eDir) check(opAddr == eAddr, req, int'(opAddr), int'(eAddr));
    check(wrCount == eWr, "R9 write count", wrCount, eWr);
    rfOk = 1'b1;
    for (int i = 0; i < 8; i++) if (rf[i] !== expRf[i]) rfOk = 1'b0;
    check(rfOk, {req, " register file"}, int'(rf[s[2:0]]), int'(expRf[s[2:0]]));
    @(posedge clk); @(negedge clk);
    check(!done, "R10 done pulse width", int'(done), 0);
    if (poke) begin
      @(posedge clk); @(negedge clk);
      check(!done && !memRdReq && wrCount == eWr, "R11 ignored start", wrCount, eWr);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin rf[i] = '0; rfInit[i] = '0; expRf[i] = '0; end
    repeat (3) @(negedge clk);
    check(!done && !memRdReq && !regWrEn, "R10 reset idle", int'({done, memRdReq, regWrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      runVec(VEC[v][9:4], VEC[v][3], int'(VEC[v][2:0]), 1'b0);

    // R11: start raised mid-operation must not disturb the specifier in flight
    runVec(6'o73, 1'b1, 2, 1'b1);

    // Reset in the middle of an index fetch returns to idle
    @(negedge clk); rfLoad = 1'b1; waitCfg = 3;
    @(negedge clk); rfLoad = 1'b0; spec = 6'o62; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    @(posedge clk); @(negedge clk);
    check(memRdReq == 1'b1, "R7 index fetch pending", int'(memRdReq), 1);
    rstN = 1'b0;
    @(negedge clk);
    check(!memRdReq && !done, "R10 reset abort", int'({memRdReq, done}), 0);
    rstN = 1'b1;
    @(negedge clk);
    runVec(6'o64, 1'b0, 0, 1'b0);
    runVec(6'o50, 1'b1, 1, 1'b0);

    finishRun();
  end
endmodule